// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Break Recognition

This block receives asynchronous serial frames on a single line. An external oversample tick marks sixteen sampling points per bit period. A falling edge on an idle line starts a frame. Each bit is decided by a two-of-three vote around the bit centre, and the frame carries 8 or 9 data bits, least significant bit first. When the stop-bit decision is made, the block publishes the byte, the ninth bit and a set of sticky status flags. A read-clear strobe clears these flags once the consumer has taken the data.

A frame whose data bits are all zero and whose stop position reads low is treated as a break. In that case the framing-error, receiver-full and break flags are raised together, and the data and ninth-bit outputs are forced to zero. After a break, the line must be seen high again before another frame can begin.

Top module: `uart_brk_rx`

## Requirements
- R1: The tick on which the falling edge is seen is sample 0 of the start bit. Bit k (start is k=0) is decided by a majority of the line values at ticks 16k+7, 16k+8 and 16k+9. Disagreement at any other tick has no effect.
- R2: A start bit that votes 1 is a glitch. Reception is abandoned, no flag or data output changes, and busy_o returns low.
- R3: nine_bit_i (1 = nine data bits) is latched on the start tick. On the clock edge that takes the stop-bit vote, data_o receives the first eight data bits (first received bit in bit 0), bit9_o receives the ninth bit (0 in 8-bit mode), and full_o is set.
- R4: A stop bit that votes 0 sets fe_o.
- R5: A frame whose data bits (including the ninth in 9-bit mode) are all 0 and whose stop bit votes 0 is a break. It sets brk_o, fe_o and full_o, and drives data_o and bit9_o to 0.
- R6: In 9-bit mode, pe_o is set when the data byte together with the ninth bit holds an odd number of ones (even parity). In 8-bit mode pe_o is never set.
- R7: nf_o is set when the three votes of any bit of a completed frame disagree.
- R8: A frame that completes while full_o is set raises ovr_o. data_o, bit9_o and all other flags keep their values.
- R9: rd_clr_i clears full_o, fe_o, brk_o, ovr_o, nf_o and pe_o. When it coincides with a frame completion, the clear is applied first, so no overrun occurs and the flags reflect that frame alone.
- R10: busy_o is high from the clock after the start tick until the stop vote or a glitch abort.
- R11: A start is accepted only on a tick that sees 0 when the previous tick saw 1. After a break, or after reset, the line must be sampled high before a new frame begins.
- R12: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Serial line |
| os_tick_i | input | 1 | Oversample strobe, 16 per bit |
| nine_bit_i | input | 1 | 1 selects 9 data bits |
| rd_clr_i | input | 1 | Clears status flags |
| data_o | output | 8 | Received byte |
| bit9_o | output | 1 | Received ninth bit |
| full_o | output | 1 | Receiver full |
| fe_o | output | 1 | Framing error |
| brk_o | output | 1 | Break received |
| ovr_o | output | 1 | Overrun |
| nf_o | output | 1 | Noise seen |
| pe_o | output | 1 | Parity error |
| busy_o | output | 1 | Reception in progress |

## Verification
The read-clear strobe and a frame completion can land on the same clock edge. The bench provokes this by raising rd_clr_i exactly on the tick that carries the stop-bit vote, while full_o is still set from an earlier frame. The expected result is that full_o stays set with the new byte on data_o and ovr_o stays clear, because the clear takes effect before the completion is evaluated. A second collision occurs when a break completes: the break, framing-error and receiver-full flags must all rise on that one edge, and the data and ninth-bit outputs must be zero on the same edge.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;
  parameter int unsigned DATA_W = 8;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              b9;
    logic              fe;
    logic              brk;
    logic              nf;
    logic              pe;
  } rx_frame_t;
endpackage

// File: rtl/uart_brk_sampler.sv
module uart_brk_sampler #(
  parameter int unsigned OSR = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic rxd_i,
  input  logic active_i,
  output logic start_o,
  output logic vote_o,
  output logic bit_o,
  output logic noisy_o
);
  localparam int unsigned CW  = $clog2(OSR);
  localparam int unsigned MID = OSR / 2;

  logic [CW-1:0] cnt_q;
  logic          line_q, s_a_q, s_b_q;

  assign start_o = tick_i & line_q & ~rxd_i & ~active_i;
  assign vote_o  = tick_i & active_i & (cnt_q == CW'(MID + 1));
  assign bit_o   = (s_a_q & s_b_q) | (s_a_q & rxd_i) | (s_b_q & rxd_i);
  assign noisy_o = ~((s_a_q & s_b_q & rxd_i) | ~(s_a_q | s_b_q | rxd_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      line_q <= 1'b0;  // a line low at reset is not an edge
      s_a_q  <= 1'b0;
      s_b_q  <= 1'b0;
    end else if (tick_i) begin
      line_q <= rxd_i;
      if (start_o) cnt_q <= CW'(1);
      else if (active_i) cnt_q <= cnt_q + CW'(1);
      if (active_i && cnt_q == CW'(MID - 1)) s_a_q <= rxd_i;
      if (active_i && cnt_q == CW'(MID)) s_b_q <= rxd_i;
    end
  end
endmodule

// File: rtl/uart_brk_ctrl.sv
module uart_brk_ctrl
  import uart_brk_pkg::*;
#(
  parameter bit PAR_ODD = 1'b0
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  logic      vote_i,
  input  logic      bit_i,
  input  logic      noisy_i,
  input  logic      nine_i,
  output logic      active_o,
  output logic      done_o,
  output rx_frame_t frame_o
);
  localparam int unsigned DW = DATA_W;
  localparam int unsigned IW = $clog2(DW + 3);

  logic [IW-1:0] idx_q, last;
  logic [DW:0]   sh_q;
  logic          nine_q, nz_q;
  logic [DW-1:0] data;
  logic          b9;

  assign last   = nine_q ? IW'(DW + 2) : IW'(DW + 1);
  assign done_o = vote_i & active_o & (idx_q == last);
  assign data   = nine_q ? sh_q[DW-1:0] : sh_q[DW:1];
  assign b9     = nine_q & sh_q[DW];

  always_comb begin
    frame_o.data = data;
    frame_o.b9   = b9;
    frame_o.fe   = ~bit_i;
    frame_o.brk  = ~bit_i & ~(|data) & ~b9;
    frame_o.nf   = nz_q | noisy_i;
    frame_o.pe   = nine_q & ((^{data, b9}) != PAR_ODD);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      idx_q    <= '0;
      sh_q     <= '0;
      nine_q   <= 1'b0;
      nz_q     <= 1'b0;
    end else if (start_i) begin
      active_o <= 1'b1;
      idx_q    <= '0;
      sh_q     <= '0;
      nine_q   <= nine_i;
      nz_q     <= 1'b0;
    end else if (vote_i && active_o) begin
      if ((idx_q == '0 && bit_i) || done_o) begin
        active_o <= 1'b0;  // glitch abort or frame end
      end else begin
        if (idx_q != '0) sh_q <= {bit_i, sh_q[DW:1]};
        nz_q  <= nz_q | noisy_i;
        idx_q <= idx_q + IW'(1);
      end
    end
  end
endmodule

// File: rtl/uart_brk_status.sv
module uart_brk_status
  import uart_brk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  rx_frame_t         frame_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              b9_o,
  output logic              full_o,
  output logic              fe_o,
  output logic              brk_o,
  output logic              ovr_o,
  output logic              nf_o,
  output logic              pe_o
);
  logic keep;
  assign keep = ~clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      b9_o   <= 1'b0;
      full_o <= 1'b0;
      fe_o   <= 1'b0;
      brk_o  <= 1'b0;
      ovr_o  <= 1'b0;
      nf_o   <= 1'b0;
      pe_o   <= 1'b0;
    end else begin
      full_o <= full_o & keep;
      fe_o   <= fe_o & keep;
      brk_o  <= brk_o & keep;
      ovr_o  <= ovr_o & keep;
      nf_o   <= nf_o & keep;
      pe_o   <= pe_o & keep;
      if (done_i) begin
        if (full_o & keep) begin
          ovr_o <= 1'b1;  // new frame dropped
        end else begin
          full_o <= 1'b1;
          data_o <= frame_i.brk ? '0 : frame_i.data;
          b9_o   <= frame_i.brk ? 1'b0 : frame_i.b9;
          fe_o   <= (fe_o & keep) | frame_i.fe;
          brk_o  <= (brk_o & keep) | frame_i.brk;
          nf_o   <= (nf_o & keep) | frame_i.nf;
          pe_o   <= (pe_o & keep) | frame_i.pe;
        end
      end
    end
  end
endmodule

// File: rtl/uart_brk_rx.sv
module uart_brk_rx
  import uart_brk_pkg::*;
#(
  parameter int unsigned OSR     = 16,
  parameter bit          PAR_ODD = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rxd_i,
  input  logic              os_tick_i,
  input  logic              nine_bit_i,
  input  logic              rd_clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              bit9_o,
  output logic              full_o,
  output logic              fe_o,
  output logic              brk_o,
  output logic              ovr_o,
  output logic              nf_o,
  output logic              pe_o,
  output logic              busy_o
);
  logic      start, vote, bit_v, noisy, done;
  rx_frame_t frame;

  uart_brk_sampler #(.OSR(OSR)) u_smp (
    .clk_i, .rst_ni,
    .tick_i(os_tick_i), .rxd_i, .active_i(busy_o),
    .start_o(start), .vote_o(vote), .bit_o(bit_v), .noisy_o(noisy)
  );

  uart_brk_ctrl #(.PAR_ODD(PAR_ODD)) u_ctl (
    .clk_i, .rst_ni,
    .start_i(start), .vote_i(vote), .bit_i(bit_v), .noisy_i(noisy),
    .nine_i(nine_bit_i), .active_o(busy_o), .done_o(done), .frame_o(frame)
  );

  uart_brk_status u_sts (
    .clk_i, .rst_ni,
    .done_i(done), .frame_i(frame), .clr_i(rd_clr_i),
    .data_o, .b9_o(bit9_o), .full_o, .fe_o, .brk_o, .ovr_o, .nf_o, .pe_o
  );
endmodule

// File: rtl/uart_brk_rx_chk.sv
module uart_brk_rx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rxd_i,
  input logic       os_tick_i,
  input logic       nine_bit_i,
  input logic       rd_clr_i,
  input logic [7:0] data_o,
  input logic       bit9_o,
  input logic       full_o,
  input logic       fe_o,
  input logic       brk_o,
  input logic       ovr_o,
  input logic       nf_o,
  input logic       pe_o,
  input logic       busy_o
);
  AST_BRK_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(brk_o) |-> fe_o && full_o);  // R5
  AST_BRK_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(brk_o) |-> data_o == 8'h00 && !bit9_o);  // R5
  AST_CLR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_clr_i && !busy_o |=> !full_o && !fe_o && !brk_o && !ovr_o && !nf_o && !pe_o);  // R9
  AST_OVR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_o) |-> $stable(data_o) && $stable(bit9_o) && $stable(fe_o) && $stable(brk_o));  // R8
  AST_FULL_FROM_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_o) |-> $past(busy_o));  // R3
  AST_START_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !os_tick_i |=> $stable(busy_o));  // R10
endmodule

bind uart_brk_rx uart_brk_rx_chk u_chk (.*);

// File: tb/uart_brk_rx_tb.sv
module uart_brk_rx_tb_top;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       rxd = 1'b1, os_tick = 1'b0, nine_bit = 1'b0, rd_clr = 1'b0;
  logic [7:0] data;
  logic       bit9, full, fe, brk, ovr, nf, pe, busy;
  int         n_chk = 0, n_fail = 0;
  bit         run = 1'b0, done_all = 1'b0;

  always #4 clk = ~clk;

  uart_brk_rx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rxd_i(rxd), .os_tick_i(os_tick),
    .nine_bit_i(nine_bit), .rd_clr_i(rd_clr), .data_o(data), .bit9_o(bit9),
    .full_o(full), .fe_o(fe), .brk_o(brk), .ovr_o(ovr), .nf_o(nf),
    .pe_o(pe), .busy_o(busy)
  );

  // behavioural reference
  int         m_n;
  bit         m_busy, m_prev, m_nine, m_nz, sa, sb;
  bit         m_bits[$];
  logic [7:0] e_data;
  bit         e_b9, e_full, e_fe, e_brk, e_or, e_nf, e_pe;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_prev = 0; m_n = 0; m_nz = 0;
      e_data = 0; e_b9 = 0; e_full = 0; e_fe = 0; e_brk = 0; e_or = 0; e_nf = 0; e_pe = 0;
    end else begin
      bit cmpl, f_fe, f_brk, f_pe, f_b9;
      logic [7:0] f_d;
      cmpl = 0; f_fe = 0; f_brk = 0; f_pe = 0; f_b9 = 0; f_d = 0;
      if (os_tick) begin
        if (!m_busy) begin
          if (m_prev && !rxd) begin
            m_busy = 1; m_n = 0; m_nine = nine_bit; m_nz = 0; m_bits.delete();
          end
        end else begin
          int pos, bno, ones, nb;
          m_n++;
          pos = m_n % 16; bno = m_n / 16; nb = m_nine ? 9 : 8;
          if (pos == 7) sa = rxd;
          if (pos == 8) sb = rxd;
          if (pos == 9) begin
            ones = int'(sa) + int'(sb) + int'(rxd);
            if (ones == 1 || ones == 2) m_nz = 1;
            if (bno == 0) begin
              if (ones >= 2) m_busy = 0;
            end else if (bno <= nb) begin
              m_bits.push_back(ones >= 2);
            end else begin
              int par;
              bit allz;
              cmpl = 1; m_busy = 0; par = 0; allz = 1;
              for (int i = 0; i < nb; i++) begin
                if (i < 8) f_d[i] = m_bits[i];
                par += int'(m_bits[i]);
                if (m_bits[i]) allz = 0;
              end
              f_b9 = m_nine ? m_bits[8] : 1'b0;
              f_fe = (ones < 2);
              f_brk = f_fe && allz;
              f_pe = m_nine && (par % 2 == 1);
            end
          end
        end
        m_prev = rxd;
      end
      if (rd_clr) begin
        e_full = 0; e_fe = 0; e_brk = 0; e_or = 0; e_nf = 0; e_pe = 0;
      end
      if (cmpl) begin
        if (e_full) e_or = 1;
        else begin
          e_full = 1; e_data = f_brk ? 8'h00 : f_d; e_b9 = f_brk ? 1'b0 : f_b9;
          e_fe |= f_fe; e_brk |= f_brk; e_nf |= m_nz; e_pe |= f_pe;
        end
      end
    end
  end

  task automatic cmp(input string tag, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && run) begin
      cmp("R3 data", {1'b0, data}, {1'b0, e_data});
      cmp("R3 bit9", {8'b0, bit9}, {8'b0, e_b9});
      cmp("R3 full", {8'b0, full}, {8'b0, e_full});
      cmp("R4 fe", {8'b0, fe}, {8'b0, e_fe});
      cmp("R5 brk", {8'b0, brk}, {8'b0, e_brk});
      cmp("R8 ovr", {8'b0, ovr}, {8'b0, e_or});
      cmp("R7 nf", {8'b0, nf}, {8'b0, e_nf});
      cmp("R6 pe", {8'b0, pe}, {8'b0, e_pe});
      cmp("R10 busy", {8'b0, busy}, {8'b0, m_busy});
    end
  end

  task automatic tk(input logic v, input logic clr);
    @(negedge clk); rxd = v; os_tick = 1'b1; rd_clr = clr;
    @(negedge clk); os_tick = 1'b0; rd_clr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tk(1'b1, 1'b0);
  endtask

  task automatic clr_pulse();
    @(negedge clk); rd_clr = 1'b1;
    @(negedge clk); rd_clr = 1'b0;
  endtask

  task automatic send(input logic [8:0] d, input bit nine, input bit stopv,
                      input int fbit, input int fpos, input bit clr_end);
    int nb;
    nb = nine ? 9 : 8;
    nine_bit = nine;
    for (int b = 0; b <= nb + 1; b++) begin
      for (int p = 0; p < 16; p++) begin
        logic v;
        v = (b == 0) ? 1'b0 : (b == nb + 1) ? stopv : d[b-1];
        if (b == fbit && p == fpos) v = ~v;
        tk(v, clr_end && b == nb + 1 && p == 9);
      end
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done_all) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R12 reset outs", {busy, full, fe, brk, ovr, nf, pe, bit9, 1'b0}, 9'h0);
    cmp("R12 reset data", {1'b0, data}, 9'h0);
    run = 1'b1;
    idle(3);
    send(9'h0A5, 0, 1, -1, 0, 0); idle(2);
    cmp("R3 byte A5", {full, data}, 9'h1A5);
    clr_pulse();
    cmp("R9 clear", {1'b0, full, fe, brk, ovr, nf, pe, 2'b0}, 9'h0);
    send(9'h03C, 1, 1, -1, 0, 0); idle(2);
    cmp("R6 even parity ok", {8'b0, pe}, 9'h0);
    clr_pulse();
    send(9'h13C, 1, 1, -1, 0, 0); idle(2);
    cmp("R6 parity error", {7'b0, bit9, pe}, 9'h3);
    clr_pulse();
    send(9'h055, 0, 0, -1, 0, 0); idle(2);
    cmp("R4 framing", {6'b0, fe, brk, full}, 9'h5);
    clr_pulse();
    send(9'h000, 0, 0, -1, 0, 0);
    for (int i = 0; i < 20; i++) tk(1'b0, 1'b0);
    cmp("R11 held low no start", {8'b0, busy}, 9'h0);
    cmp("R5 break 8", {full, fe, brk, data[5:0]}, 9'h1C0);
    idle(1); tk(1'b0, 1'b0);
    cmp("R11 start after high", {8'b0, busy}, 9'h1);
    idle(40); clr_pulse();
    send(9'h1FF, 1, 1, -1, 0, 0); idle(2); clr_pulse();
    send(9'h000, 1, 0, -1, 0, 0); idle(2);
    cmp("R5 break 9 clears bit9", {bit9, data}, 9'h0);
    cmp("R5 break 9 flags", {6'b0, full, fe, brk}, 9'h7);
    clr_pulse();
    for (int i = 0; i < 4; i++) tk(1'b0, 1'b0);
    idle(20);
    cmp("R2 glitch", {7'b0, busy, full}, 9'h0);
    send(9'h00F, 0, 1, 3, 8, 0); idle(2);
    cmp("R7 noise", {nf, data}, 9'h10F);
    clr_pulse();
    send(9'h00F, 0, 1, 3, 5, 0); idle(2);
    cmp("R1 outside window", {nf, data}, 9'h00F);
    clr_pulse();
    send(9'h011, 0, 1, -1, 0, 0); idle(2);
    send(9'h022, 0, 1, -1, 0, 0); idle(2);
    cmp("R8 overrun", {ovr, data}, 9'h111);
    clr_pulse();
    send(9'h033, 0, 1, -1, 0, 0); idle(2);
    send(9'h044, 0, 1, -1, 0, 1); idle(2);
    cmp("R9 same-edge clear", {full, data}, 9'h144);
    cmp("R9 no overrun", {8'b0, ovr}, 9'h0);
    idle(4);
    done_all = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule